// File: doc/BRIEF.md
# Byte-Wide Configuration Slave Receiver

This block sits on the target side of a byte-parallel configuration load interface. On every rising edge of the configuration clock it samples an active-low select, an active-low write strobe and a data byte. When a write is presented and the port is free, the byte is captured and handed to an internal frame-loading stream as a one-cycle pulse together with the byte. A busy output holds the host back whenever the downstream byte consumer cannot take more data.

The port also watches how the host drives the interface. If the write strobe changes level between two consecutive clocks on which the port is selected, the port treats this as a protocol violation and enters an abort state. It accepts nothing until the host releases the select line. A running count of accepted bytes is kept for the loader. It wraps at its width and is cleared by the active-low reset.

Top module: `pcfg_slave_port`

## Requirements
- R1: A byte is accepted on a rising edge where select is low, write strobe is low, busy is low, abort is low and no violation is detected on that edge. On the following cycle `byte_vld` is 1 for exactly that cycle and `byte_out` carries the byte that was sampled.
- R2: On an edge where `busy` is 1, the presented byte is not accepted. The host keeps the write presented, and the byte is accepted at the first edge that samples `busy` at 0.
- R3: `busy` becomes 1 on the cycle after an acceptance if `sink_ready` was 0 at the accepting edge.
- R4: Once set, `busy` stays 1 until an edge samples `sink_ready` at 1. It is 0 from the cycle after that edge.
- R5: A violation is a clock edge where select is low, select was also low at the previous edge, and `wr_n` differs from its level at that previous edge. A violation sets `abort` on the next cycle, and the byte at the violating edge is not accepted.
- R6: `abort` stays 1 while select stays low. It clears on the cycle after an edge that samples select high.
- R7: No byte is accepted while `abort` is 1.
- R8: Raising select and write strobe together ends a write sequence without an abort. Changes of `wr_n` while select is high never cause an abort.
- R9: `byte_count` increments by one for each accepted byte, wraps modulo 2^CNT_W, and does not change otherwise.
- R10: While `rst_n` is low and after its release: `busy`, `abort`, `byte_vld` and `byte_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | configuration clock, rising-edge sampling |
| rst_n | input | 1 | asynchronous active-low reset |
| sel_n | input | 1 | active-low port select |
| wr_n | input | 1 | active-low write strobe |
| din | input | DATA_W | configuration data bus |
| sink_ready | input | 1 | downstream byte consumer can take a byte |
| busy | output | 1 | back-pressure to the host |
| abort | output | 1 | protocol violation seen, held while selected |
| byte_out | output | DATA_W | last accepted byte |
| byte_vld | output | 1 | one-cycle strobe for an accepted byte |
| byte_count | output | CNT_W | accepted-byte count, wrapping |

## Verification
A full run of 256 byte values with the consumer always ready checks the data path and the counter wrap. Any dropped, duplicated or corrupted byte shows up there. Every ordered pair of (select, strobe) levels on two consecutive edges is then applied from idle and followed by a held write. This separates true violations from normal sequence ends and from strobe changes while deselected. A pseudo-random `sink_ready` pattern under a held write tests busy assertion and release. A long post-violation window with the write still presented shows whether abort blocks acceptance and whether deselection clears it.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
   // one sampled view of the host-side control pins
   typedef struct packed {
      logic selected;
      logic wr_n;
   } ctl_smp_t;

   function automatic ctl_smp_t sample_ctl(input logic sel_n, input logic wr_n);
      ctl_smp_t s;
      s.selected = ~sel_n;
      s.wr_n     = wr_n;
      return s;
   endfunction

   localparam ctl_smp_t CTL_IDLE = '{selected: 1'b0, wr_n: 1'b1};
endpackage

// File: rtl/pcfg_proto_mon.sv
module pcfg_proto_mon
   import pcfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic wr_n,
   output logic viol,
   output logic abort
);
   ctl_smp_t cur_s, prev_s;

   assign cur_s = sample_ctl(sel_n, wr_n);
   // strobe level changed across two selected edges
   assign viol  = cur_s.selected & prev_s.selected & (cur_s.wr_n ^ prev_s.wr_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_s <= CTL_IDLE;
         abort  <= 1'b0;
      end else begin
         prev_s <= cur_s;
         if (!cur_s.selected) abort <= 1'b0;
         else if (viol)       abort <= 1'b1;
      end
   end
endmodule

// File: rtl/pcfg_flow_ctl.sv
module pcfg_flow_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic sink_ready,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (sink_ready) busy <= 1'b0;
      else if (accept)     busy <= 1'b1;
   end
endmodule

// File: rtl/pcfg_byte_out.sv
module pcfg_byte_out #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter bit          HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              vld,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld   <= 1'b0;
         count <= '0;
      end else begin
         vld <= accept;
         if (accept) count <= count + CNT_ONE;
      end
   end

   generate
      if (HOLD_DATA) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dout <= '0;
            else if (accept) dout <= din;
         end
      end else begin : g_gate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= '0;
            else        dout <= accept ? din : '0;
         end
      end
   endgenerate
endmodule

// File: rtl/pcfg_slave_port.sv
module pcfg_slave_port #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter bit          HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   input  logic              sink_ready,
   output logic              busy,
   output logic              abort,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_vld,
   output logic [CNT_W-1:0]  byte_count
);
   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("pcfg_slave_port: DATA_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pcfg_slave_port: CNT_W out of range");
      end
   endgenerate

   logic viol;
   logic accept;

   assign accept = ~sel_n & ~wr_n & ~busy & ~abort & ~viol;

   pcfg_proto_mon mon_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_n (sel_n),
      .wr_n  (wr_n),
      .viol  (viol),
      .abort (abort)
   );

   pcfg_flow_ctl flow_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .sink_ready (sink_ready),
      .busy       (busy)
   );

   pcfg_byte_out #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .HOLD_DATA (HOLD_DATA)
   ) out_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .din    (din),
      .dout   (byte_out),
      .vld    (byte_vld),
      .count  (byte_count)
   );
endmodule

// File: rtl/pcfg_slave_port_chk.sv
module pcfg_slave_port_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              wr_n,
   input logic              sink_ready,
   input logic              busy,
   input logic              abort,
   input logic              byte_vld,
   input logic [CNT_W-1:0]  byte_count
);
   logic ck_psel, ck_pw;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_psel <= 1'b0;
         ck_pw   <= 1'b1;
      end else begin
         ck_psel <= ~sel_n;
         ck_pw   <= wr_n;
      end
   end

   p_accept_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(~sel_n & ~wr_n & ~busy & ~abort));

   p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !byte_vld);

   p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> byte_vld);

   p_busy_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sink_ready |=> !busy);

   p_flip_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && ck_psel && (wr_n != ck_pw)) |=> (abort && !byte_vld));

   p_abort_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !sel_n) |=> abort);

   p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !abort);

   p_abort_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !byte_vld);

   p_count_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |-> $stable(byte_count));

   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r10: assert (!busy && !abort && !byte_vld && byte_count == '0);
      end
   end
endmodule

bind pcfg_slave_port pcfg_slave_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_n      (sel_n),
   .wr_n       (wr_n),
   .sink_ready (sink_ready),
   .busy       (busy),
   .abort      (abort),
   .byte_vld   (byte_vld),
   .byte_count (byte_count)
);

// File: tb/pcfg_slave_port_tb_top.sv
module pcfg_slave_port_tb_top;
   localparam int DW = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sel_n, wr_n, sink_ready;
   logic [DW-1:0] din;
   logic          busy, abort, byte_vld;
   logic [DW-1:0] byte_out;
   logic [CW-1:0] byte_count;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference state built from the requirements
   logic          m_psel, m_pw, m_busy, m_abort, m_vld;
   logic [DW-1:0] m_data;
   logic [CW-1:0] m_cnt;

   always #2 clk = ~clk;

   pcfg_slave_port #(.DATA_W(DW), .CNT_W(CW), .HOLD_DATA(1'b1)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n      (sel_n),
      .wr_n       (wr_n),
      .din        (din),
      .sink_ready (sink_ready),
      .busy       (busy),
      .abort      (abort),
      .byte_out   (byte_out),
      .byte_vld   (byte_vld),
      .byte_count (byte_count)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // drive one cycle, advance the reference, compare after the edge
   task automatic cyc(input logic s, input logic w, input logic [DW-1:0] d,
                      input logic r, input string ph);
      logic sel, viol, acc;
      sel_n = s; wr_n = w; din = d; sink_ready = r;
      @(posedge clk); #1;
      sel  = ~s;
      viol = sel & m_psel & (w ^ m_pw);
      acc  = sel & ~w & ~m_busy & ~m_abort & ~viol;
      m_abort = sel ? (m_abort | viol) : 1'b0;
      m_busy  = ~r & (acc | m_busy);
      m_vld   = acc;
      if (acc) begin
         m_data = d;
         m_cnt  = m_cnt + 1'b1;
      end
      m_psel = sel; m_pw = w;
      chk(byte_vld == m_vld, {ph, "/R1"}, "byte_vld", byte_vld, m_vld);
      if (m_vld) chk(byte_out == m_data, {ph, "/R1"}, "byte_out", byte_out, m_data);
      chk(busy == m_busy, {ph, "/R3"}, "busy", busy, m_busy);
      chk(abort == m_abort, {ph, "/R5"}, "abort", abort, m_abort);
      chk(byte_count == m_cnt, {ph, "/R9"}, "byte_count", byte_count, m_cnt);
   endtask

   initial begin
      #(4 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; din = '0; sink_ready = 1'b1;
      m_psel = 1'b0; m_pw = 1'b1; m_busy = 1'b0; m_abort = 1'b0;
      m_vld = 1'b0; m_data = '0; m_cnt = '0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk(busy == 1'b0,  "R10", "busy",  busy, 0);
      chk(abort == 1'b0, "R10", "abort", abort, 0);
      chk(byte_vld == 1'b0, "R10", "byte_vld", byte_vld, 0);
      chk(byte_count == '0, "R10", "byte_count", byte_count, 0);
      rst_n = 1'b1;
      cyc(1, 1, 8'h00, 1, "R10");

      // R1 / R9: stream all byte values, consumer always ready; count wraps
      for (int v = 0; v < 256; v++) cyc(0, 0, 8'(v), 1, "R1");
      cyc(0, 0, 8'h5A, 1, "R9");
      chk(byte_count == 8'd1, "R9", "wrap count", byte_count, 1);
      cyc(1, 1, 8'h00, 1, "R8");

      // R5 / R8: every ordered pair of control levels from idle, then a held write
      for (int k = 0; k < 16; k++) begin
         cyc(1, 1, 8'h00, 1, "R8");
         cyc(k[3], k[2], 8'(k + 8'h40), 1, "R5");
         cyc(k[1], k[0], 8'(k + 8'h80), 1, "R5");
         cyc(0, 0, 8'(k + 8'hC0), 1, "R6");
         cyc(1, 1, 8'h00, 1, "R8");
      end

      // R8: strobe toggling while deselected never aborts
      for (int k = 0; k < 6; k++) cyc(1, k[0], 8'h11, 1, "R8");
      chk(abort == 1'b0, "R8", "abort after deselected toggles", abort, 0);

      // R2 / R3 / R4: held write against a pseudo-random consumer
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(0, 0, 8'(k), lfsr[0] & lfsr[3], (k % 2) ? "R2" : "R4");
      end
      // R4: ready returns, busy releases one cycle later
      cyc(0, 1, 8'h00, 1, "R4");
      cyc(1, 1, 8'h00, 1, "R4");
      chk(busy == 1'b0, "R4", "busy after ready", busy, 0);

      // R6 / R7: violation, then a long held write is refused until deselect
      cyc(0, 1, 8'h21, 1, "R6");
      cyc(0, 0, 8'h22, 1, "R5");
      for (int k = 0; k < 20; k++) cyc(0, 0, 8'(k + 8'h30), 1, "R7");
      chk(abort == 1'b1, "R6", "abort held", abort, 1);
      cyc(1, 1, 8'h00, 1, "R6");
      chk(abort == 1'b0, "R6", "abort after deselect", abort, 0);
      cyc(0, 0, 8'h77, 1, "R1");
      chk(byte_vld == 1'b1, "R7", "accept resumes", byte_vld, 1);
      cyc(1, 1, 8'h00, 1, "R8");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule